// File: doc/BRIEF.md
# DMA Interrupt Mask and Latch

This unit gathers the fatal DMA events of a bus-master controller into one sticky cause register, applies a software-written enable mask to decide which causes may pull an active-low interrupt pin, and holds that pin low until software reads the cause register. A read of the cause register returns its bits and clears them in the same access.

Two signals ignore the mask. A summary pending flag reports any cause that is set. A halt request tells the script engine to stop, because every DMA cause is fatal. A function-select input picks which of two interrupt pins carries the latched request. The other pin stays high.

Register reads return data one cycle after the read strobe. Bit positions are shared by the event inputs, the cause register and the enable register: bit 6 is parity error, 5 is bus fault, 4 is abort, 3 is single-step, 2 is script interrupt, and 0 is illegal instruction. Bits 7 and 1 are reserved.

Top module: `dmairq_unit`

## Requirements
- R1: After reset, both pins are high, `dma_pend` and `halt_req` are 0, and both registers read 0x00.
- R2: The enable register reads back the written value with reserved bits 7 and 1 forced to 0. Writing 0xFF therefore reads back 0x7D.
- R3: A status read (`rd_sel`=1) returns the sticky cause bits on `rd_data` one cycle after `rd_en`, and clears those bits.
- R4: A cause whose enable bit is 0 does not pull either pin low.
- R5: Any set cause bit makes `dma_pend` 1 on the cycle after the event, whether the cause is masked or not.
- R6: Any defined event raises `halt_req` on the cycle after the event, whether the cause is masked or not.
- R7: A cause that is set and enabled pulls the selected pin low one cycle after the cause bit is set. `fn_sel`=0 selects `irq_a_n` and `fn_sel`=1 selects `irq_b_n`. The other pin stays high.
- R8: Clearing enable bits after the pin has gone low does not release the pin.
- R9: The pin is released by a status read, and is high on the cycle after the read.
- R10: A masked cause that is already pending does not stop a later enabled cause from pulling the pin low.
- R11: An event that arrives in the same cycle as a status read is not part of that read's data. It stays set for the next read, and `dma_pend` and `halt_req` stay 1.
- R12: Events on reserved bits 7 and 1 are ignored. They set no cause bit, no pin, no pending flag and no halt.
- R13: `halt_req` falls only after a status read that leaves no cause bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event strobes, in register bit positions |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Data to write into the enable register |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Register selected for the read: 0 is enable, 1 is status (a status read clears it) |
| fn_sel | input | 1 | Selects which interrupt pin is used |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq_a_n | output | 1 | Active-low latched interrupt, function A |
| irq_b_n | output | 1 | Active-low latched interrupt, function B |
| dma_pend | output | 1 | Any cause set, regardless of the mask |
| halt_req | output | 1 | Stop request to the script engine |

## Verification
The hardest case is a fresh event that lands in the same cycle as the status read that clears the register. The read data must leave the new event out, and the new event must survive into the next read. The bench drives the event strobe and the read strobe on the same falling edge. Its scoreboard expects the older cause bits from the first read and the new bit alone from the second. A second awkward ordering is a pin that is already low when its enable bit is cleared. The stimulus clears the mask and checks the pin before any read is issued.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int REG_W = 8;

    localparam int B_PARITY  = 6;
    localparam int B_BUSFLT  = 5;
    localparam int B_ABORT   = 4;
    localparam int B_STEP    = 3;
    localparam int B_SCRIPT  = 2;
    localparam int B_ILLEGAL = 0;

    localparam logic [REG_W-1:0] DEF_MASK =
        (REG_W'(1) << B_PARITY) | (REG_W'(1) << B_BUSFLT) |
        (REG_W'(1) << B_ABORT)  | (REG_W'(1) << B_STEP)   |
        (REG_W'(1) << B_SCRIPT) | (REG_W'(1) << B_ILLEGAL);

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic rsv7;
        logic parity;
        logic busflt;
        logic abort;
        logic step;
        logic script;
        logic rsv1;
        logic illegal;
    } dma_cause_t;

    function automatic dma_cause_t keep_defined(input logic [REG_W-1:0] v);
        return dma_cause_t'(v & DEF_MASK);
    endfunction

    function automatic logic any_cause(input dma_cause_t c);
        return |(c & DEF_MASK);
    endfunction

endpackage

// File: rtl/dmairq_enable_reg.sv
module dmairq_enable_reg
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output dma_cause_t       en_q
);
    dma_cause_t en_r;

    always_ff @(posedge clk) begin
        if (rst)
            en_r <= '0;
        else if (wr_en)
            en_r <= keep_defined(wr_data);
    end

    assign en_q = en_r;

    AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en_r & ~DEF_MASK) == '0); // R2

endmodule

// File: rtl/dmairq_status_reg.sv
module dmairq_status_reg
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt,
    input  logic             rd_clr,
    output dma_cause_t       stat_q,
    output logic             halt_q
);
    dma_cause_t new_evt;
    dma_cause_t stat_r;
    dma_cause_t stat_nx;
    logic       halt_r;
    logic       halt_nx;

    always_comb begin
        new_evt = keep_defined(evt);
        if (rd_clr)
            stat_nx = new_evt;
        else
            stat_nx = stat_r | new_evt;
        if (any_cause(new_evt))
            halt_nx = 1'b1;
        else if (rd_clr)
            halt_nx = 1'b0;
        else
            halt_nx = halt_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_r <= '0;
            halt_r <= 1'b0;
        end else begin
            stat_r <= stat_nx;
            halt_r <= halt_nx;
        end
    end

    assign stat_q = stat_r;
    assign halt_q = halt_r;

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
        any_cause(dma_cause_t'(evt)) |=> ((stat_r & $past(evt & DEF_MASK)) == $past(evt & DEF_MASK))); // R5
    AST_HALT_ON_EVT: assert property (@(posedge clk) disable iff (rst)
        any_cause(dma_cause_t'(evt)) |=> halt_r); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && (evt & DEF_MASK) == '0) |=> (stat_r == '0)); // R3
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halt_r && !rd_clr) |=> halt_r); // R13
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (stat_r & ~DEF_MASK) == '0); // R12

endmodule

// File: rtl/dmairq_pin_latch.sv
module dmairq_pin_latch
    import dmairq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dma_cause_t stat_q,
    input  dma_cause_t en_q,
    input  logic       clr,
    output logic       pin_q
);
    logic pin_r;
    logic hit;

    always_comb begin
        hit = any_cause(stat_q & en_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pin_r <= 1'b0;
        else if (clr)
            pin_r <= 1'b0;
        else if (hit)
            pin_r <= 1'b1;
    end

    assign pin_q = pin_r;

    AST_PIN_STAYS: assert property (@(posedge clk) disable iff (rst)
        (pin_r && !clr) |=> pin_r); // R8
    AST_PIN_RISES: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr) |=> pin_r); // R7
    AST_PIN_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_r) |-> $past(hit)); // R4

endmodule

// File: rtl/dmairq_unit.sv
module dmairq_unit
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt_i,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_wdata,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic             fn_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_a_n,
    output logic             irq_b_n,
    output logic             dma_pend,
    output logic             halt_req
);
    dma_cause_t       en_q;
    dma_cause_t       stat_q;
    logic             halt_q;
    logic             pin_q;
    logic             stat_rd;
    logic [REG_W-1:0] rd_r;

    assign stat_rd = rd_en && (reg_sel_e'(rd_sel) == SEL_STATUS);

    dmairq_enable_reg u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (en_wr),
        .wr_data (en_wdata),
        .en_q    (en_q)
    );

    dmairq_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_i),
        .rd_clr (stat_rd),
        .stat_q (stat_q),
        .halt_q (halt_q)
    );

    dmairq_pin_latch u_pin (
        .clk    (clk),
        .rst    (rst),
        .stat_q (stat_q),
        .en_q   (en_q),
        .clr    (stat_rd),
        .pin_q  (pin_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_r <= '0;
        else if (rd_en)
            rd_r <= stat_rd ? REG_W'(stat_q) : REG_W'(en_q);
    end

    assign rd_data  = rd_r;
    assign dma_pend = any_cause(stat_q);
    assign halt_req = halt_q;
    assign irq_a_n  = ~(pin_q && !fn_sel);
    assign irq_b_n  = ~(pin_q && fn_sel);

    AST_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
        (irq_a_n || irq_b_n)); // R7
    AST_PEND_IMPLIES_HALT: assert property (@(posedge clk) disable iff (rst)
        dma_pend |-> halt_req); // R6
    AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (irq_a_n && irq_b_n)); // R9

endmodule

// File: tb/sim_dmairq_unit.sv
module sim_dmairq_unit;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_i = '0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic       fn_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq_a_n, irq_b_n, dma_pend, halt_req;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_due = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmairq_unit u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .en_wr(en_wr), .en_wdata(en_wdata),
        .rd_en(rd_en), .rd_sel(rd_sel), .fn_sel(fn_sel), .rd_data(rd_data),
        .irq_a_n(irq_a_n), .irq_b_n(irq_b_n), .dma_pend(dma_pend), .halt_req(halt_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected read value per read strobe
    always @(posedge clk) mon_due <= rd_en;
    always @(negedge clk) begin
        if (mon_due) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL scoreboard actual=%h expected=none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_en_reg(input logic [7:0] v);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    // driver: read with optional simultaneous event, expected pushed to scoreboard
    task automatic rd_reg(input logic sel, input logic [7:0] ev,
                          input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        rd_en = 1'b1; rd_sel = sel; evt_i = ev;
        @(negedge clk);
        rd_en = 1'b0; evt_i = '0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_a_n", irq_a_n, 1); check("R1 irq_b_n", irq_b_n, 1);
        check("R1 pend", dma_pend, 0);   check("R1 halt", halt_req, 0);
        rd_reg(0, 0, 8'h00, "R1 enable rd");
        rd_reg(1, 0, 8'h00, "R1 status rd");

        // R2 reserved bits of enable read 0
        wr_en_reg(8'hFF);
        rd_reg(0, 0, 8'h7D, "R2 enable rd");

        // R4 R5 R6 masked bus fault
        wr_en_reg(8'h00);
        pulse(8'h20);
        check("R5 pend masked", dma_pend, 1);
        check("R6 halt masked", halt_req, 1);
        idle(2);
        check("R4 pin masked", irq_a_n, 1);
        rd_reg(1, 0, 8'h20, "R3 status rd");
        check("R3 pend after rd", dma_pend, 0);
        check("R13 halt after clean rd", halt_req, 0);
        check("R4 pin still high", irq_a_n, 1);

        // R7 R8 R9 enabled pin latch
        wr_en_reg(8'h20);
        pulse(8'h20);
        check("R13 halt held before rd", halt_req, 1);
        @(negedge clk);
        check("R7 irq_a_n low", irq_a_n, 0);
        check("R7 irq_b_n high", irq_b_n, 1);
        wr_en_reg(8'h00);
        idle(2);
        check("R8 pin held after unmask", irq_a_n, 0);
        rd_reg(1, 0, 8'h20, "R9 status rd");
        check("R9 pin released", irq_a_n, 1);

        // R10 masked pending cause does not block enabled one
        wr_en_reg(8'h01);
        pulse(8'h08);
        idle(1);
        check("R10 masked step no pin", irq_a_n, 1);
        pulse(8'h01);
        @(negedge clk);
        check("R10 illegal pulls pin", irq_a_n, 0);
        rd_reg(1, 0, 8'h09, "R10 status rd");
        check("R10 pin released", irq_a_n, 1);

        // R11 event in the read cycle survives
        wr_en_reg(8'h00);
        pulse(8'h10);
        rd_reg(1, 8'h40, 8'h10, "R11 first rd");
        check("R11 pend kept", dma_pend, 1);
        check("R11 halt kept", halt_req, 1);
        rd_reg(1, 0, 8'h40, "R11 second rd");
        check("R13 halt cleared", halt_req, 0);

        // R7 function B
        fn_sel = 1'b1;
        wr_en_reg(8'h04);
        pulse(8'h04);
        @(negedge clk);
        check("R7 irq_b_n low", irq_b_n, 0);
        check("R7 irq_a_n high fnB", irq_a_n, 1);
        rd_reg(1, 0, 8'h04, "R7 status rd");
        fn_sel = 1'b0;

        // R12 reserved events ignored
        wr_en_reg(8'hFF);
        pulse(8'h82);
        check("R12 pend", dma_pend, 0);
        check("R12 halt", halt_req, 0);
        idle(1);
        check("R12 pin a", irq_a_n, 1);
        check("R12 pin b", irq_b_n, 1);
        rd_reg(1, 0, 8'h00, "R12 status rd");
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule